// File: doc/BRIEF.md
# Three-Prediction Global-History Branch Direction Predictor

This block predicts the directions of up to three conditional branches in one fetch group from a single table read. The table index is the global branch-history register XORed with the low bits of the fetch address. Each table entry packs several 2-bit saturating counters. Counter selection within the entry depends on the branch's position in the group, so all three predictions come from one index and not from three separate lookups.

A parameter picks one of two entry layouts. The flat layout has three counters, one per branch position. The tree layout has seven counters: the first branch's outcome picks one of two counters for the second branch, and the first two outcomes pick one of four counters for the third. In the tree layout the history and index are one bit narrower, so the storage stays about the same. At lookup the tree is walked with the predicted directions; at update it is walked with the resolved outcomes.

The fetch logic reads predictions from the combinational lookup port. When the branches of a fetch group resolve, the index that was returned for the group comes back on the update port, together with the number of resolved branches and their outcomes. That update trains the counters and advances the history at the next clock edge.

Top module: `multi_branch_predictor`

## Requirements
- R1: `lookupIdx` equals the history register XOR the low history-width bits of `lookupAddr`, zero-extended to the port width.
- R2: In the flat layout, bit k of `predTaken` (bit 0 is the first branch in the group) is taken when counter k of the indexed entry holds 2 or 3.
- R3: Each counter moves up by one on a taken outcome and down by one on a not-taken outcome. It stays at 3 when it is already at 3 and stays at 0 when it is already at 0.
- R4: An update with `updValid` high trains only the first `updCount` counters of entry `updIdx`, using bit k of `updTaken` as the outcome of branch k. With `updValid` low, or with `updCount` 0, no counter changes.
- R5: On update, the history shifts left by `updCount` places. The resolved outcomes are shifted in oldest first, so the last resolved branch lands in bit 0. The history holds its value when `updValid` is low or `updCount` is 0.
- R6: Reset (active-low `rstN`, asynchronous) clears the history to zero and sets every counter to 1, weakly not-taken. This applies both at power-up and in mid-run.
- R7: In the tree layout, branch 1 uses counter 0, branch 2 uses counter 1+d0, and branch 3 uses counter 3+2*d0+d1. At lookup, d0 and d1 are the predicted directions; at update they are the resolved outcomes.
- R8: In the tree layout, the history and index are `IDX_W`-1 bits wide. The top bit of `lookupIdx` is 0, and the top bit of `updIdx` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupAddr | input | ADDR_W | Fetch address of the group being predicted |
| lookupIdx | output | IDX_W | Table index used for this lookup, returned later on update |
| predTaken | output | 3 | Predicted directions; bit k is branch k of the group |
| updValid | input | 1 | Update strobe |
| updIdx | input | IDX_W | Index the group was predicted with |
| updCount | input | 2 | Number of resolved branches, 0 to 3 |
| updTaken | input | 3 | Resolved outcomes; bit k is branch k |

## Verification
Several properties are checked on every cycle:
- The history holds still whenever no outcomes are being shifted in.
- A counter that is already saturated stays saturated when pushed further in the same direction.
- The control trains exactly as many counters as it was given resolved branches, and none when idle.
- In the tree layout, the index never uses its top bit.

Other behaviours need the bench's scenarios. Examples are the order in which outcomes enter the history, the exact counter values seen through the predictions, the isolation of one entry from another, and the way the tree layout switches counters along a path. The bench builds those scenarios from known update sequences.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  localparam int MAX_CTRS = 7;

  // Strobes passed from update control to the datapath
  typedef struct packed {
    logic [MAX_CTRS-1:0] train;    // counter slot is trained this cycle
    logic [MAX_CTRS-1:0] dir;      // 1 = move toward taken
    logic [1:0]          shiftCnt; // outcomes entering history
    logic [2:0]          outcome;  // resolved directions, bit k = branch k
  } trainStrobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    if (up) satStep = (cur == 2'd3) ? 2'd3 : cur + 2'd1;
    else    satStep = (cur == 2'd0) ? 2'd0 : cur - 2'd1;
  endfunction

endpackage

// File: rtl/mbp_ctrl.sv
module mbp_ctrl
  import mbp_pkg::*;
#(
  parameter bit TREE_MODE = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         updValid,
  input  logic [1:0]   updCount,
  input  logic [2:0]   updTaken,
  output trainStrobe_t strobe
);

  generate
    if (TREE_MODE) begin : g_tree
      always_comb begin
        int sel1;
        int sel2;
        strobe = '0;
        sel1 = 1 + int'(updTaken[0]);
        sel2 = 3 + 2 * int'(updTaken[0]) + int'(updTaken[1]);
        if (updValid) begin
          strobe.shiftCnt = updCount;
          strobe.outcome  = updTaken;
          if (updCount >= 2'd1) begin
            strobe.train[0] = 1'b1;
            strobe.dir[0]   = updTaken[0];
          end
          if (updCount >= 2'd2) begin
            strobe.train[sel1] = 1'b1;
            strobe.dir[sel1]   = updTaken[1];
          end
          if (updCount == 2'd3) begin
            strobe.train[sel2] = 1'b1;
            strobe.dir[sel2]   = updTaken[2];
          end
        end
      end
    end else begin : g_flat
      always_comb begin
        strobe = '0;
        if (updValid) begin
          strobe.shiftCnt = updCount;
          strobe.outcome  = updTaken;
          for (int k = 0; k < 3; k++) begin
            if (2'(k) < updCount) begin
              strobe.train[k] = 1'b1;
              strobe.dir[k]   = updTaken[k];
            end
          end
        end
      end
    end
  endgenerate

  // R4: one trained counter per resolved branch
  a_r4_train_count: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> ($countones(strobe.train) == int'(updCount)));

  // R4, R5: idle update port touches nothing
  a_r4_idle: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> (strobe.train == '0 && strobe.shiftCnt == 2'd0));

endmodule

// File: rtl/mbp_dpath.sv
module mbp_dpath
  import mbp_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ADDR_W    = 32,
  parameter bit TREE_MODE = 1'b0,
  localparam int HIST_W   = TREE_MODE ? IDX_W - 1 : IDX_W,
  localparam int NCTR     = TREE_MODE ? 7 : 3,
  localparam int DEPTH    = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [IDX_W-1:0]  updIdx,
  input  trainStrobe_t      strobe,
  output logic [IDX_W-1:0]  lookupIdx,
  output logic [2:0]        predTaken
);

  logic [HIST_W-1:0]  hist;
  logic [2*NCTR-1:0]  ctrTab [DEPTH];
  logic [HIST_W-1:0]  curIdx;
  logic [HIST_W-1:0]  wrIdx;
  logic [2*NCTR-1:0]  curEntry;
  logic               unusedBits;

  assign curIdx     = hist ^ lookupAddr[HIST_W-1:0];
  assign wrIdx      = updIdx[HIST_W-1:0];
  assign curEntry   = ctrTab[curIdx];
  assign lookupIdx  = IDX_W'(curIdx);
  assign unusedBits = ^{strobe, lookupAddr, updIdx};

  // Prediction select: variant picked by entry layout
  generate
    if (TREE_MODE) begin : g_treeSel
      always_comb begin
        int s1;
        int s2;
        predTaken[0] = curEntry[1];
        s1 = 1 + int'(predTaken[0]);
        predTaken[1] = curEntry[2*s1+1];
        s2 = 3 + 2 * int'(predTaken[0]) + int'(predTaken[1]);
        predTaken[2] = curEntry[2*s2+1];
      end
    end else begin : g_flatSel
      for (genvar k = 0; k < 3; k++) begin : g_bit
        assign predTaken[k] = curEntry[2*k+1];
      end
    end
  endgenerate

  // Counter table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) ctrTab[e] <= {NCTR{2'b01}};
    end else begin
      for (int k = 0; k < NCTR; k++) begin
        if (strobe.train[k])
          ctrTab[wrIdx][2*k +: 2] <= satStep(ctrTab[wrIdx][2*k +: 2], strobe.dir[k]);
      end
    end
  end

  // Global history, oldest resolved outcome shifted in first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
    end else begin
      case (strobe.shiftCnt)
        2'd1:    hist <= {hist[HIST_W-2:0], strobe.outcome[0]};
        2'd2:    hist <= {hist[HIST_W-3:0], strobe.outcome[0], strobe.outcome[1]};
        2'd3:    hist <= {hist[HIST_W-4:0], strobe.outcome[0], strobe.outcome[1],
                          strobe.outcome[2]};
        default: hist <= hist;
      endcase
    end
  end

  // R5: history frozen without resolved outcomes
  a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftCnt == 2'd0) |=> $stable(hist));

  // R3: saturation at the top
  a_r3_sat_top: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.train[0] && strobe.dir[0] && ctrTab[wrIdx][1:0] == 2'd3)
    |=> (ctrTab[$past(wrIdx)][1:0] == 2'd3));

  // R3: saturation at the bottom
  a_r3_sat_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.train[0] && !strobe.dir[0] && ctrTab[wrIdx][1:0] == 2'd0)
    |=> (ctrTab[$past(wrIdx)][1:0] == 2'd0));

  generate
    if (TREE_MODE) begin : g_topBit
      // R8: narrowed index never sets its top bit
      a_r8_idx_top: assert property (@(posedge clk) disable iff (!rstN)
        lookupIdx[IDX_W-1] == 1'b0);
    end
  endgenerate

endmodule

// File: rtl/multi_branch_predictor.sv
module multi_branch_predictor
  import mbp_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int ADDR_W    = 32,
  parameter bit TREE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic [IDX_W-1:0]  lookupIdx,
  output logic [2:0]        predTaken,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [1:0]        updCount,
  input  logic [2:0]        updTaken
);

  trainStrobe_t strobe;

  mbp_ctrl #(.TREE_MODE(TREE_MODE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updCount (updCount),
    .updTaken (updTaken),
    .strobe   (strobe)
  );

  mbp_dpath #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .TREE_MODE(TREE_MODE)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .lookupAddr (lookupAddr),
    .updIdx     (updIdx),
    .strobe     (strobe),
    .lookupIdx  (lookupIdx),
    .predTaken  (predTaken)
  );

endmodule

// File: tb/multi_branch_predictor_test.sv
module multi_branch_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic        v;
    logic [5:0]  idx;
    logic [1:0]  cnt;
    logic [2:0]  tk;
    logic [31:0] addr;
    logic [5:0]  expIdx;
    logic [2:0]  expPred;
  } vec_t;

  // Flat layout, IDX_W=6. Expected values follow from R2..R5 starting at counters=1, history=0.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'd5, 2'd3, 3'b111, 32'd2,  6'd5, 3'b111},
    '{1'b1, 6'd5, 2'd2, 3'b001, 32'd27, 6'd5, 3'b101},
    '{1'b1, 6'd5, 2'd1, 3'b000, 32'd57, 6'd5, 3'b101},
    '{1'b0, 6'd5, 2'd3, 3'b000, 32'd57, 6'd5, 3'b101},
    '{1'b1, 6'd5, 2'd0, 3'b111, 32'd57, 6'd5, 3'b101},
    '{1'b1, 6'd5, 2'd3, 3'b111, 32'd34, 6'd5, 3'b111},
    '{1'b1, 6'd5, 2'd3, 3'b111, 32'd58, 6'd5, 3'b111},
    '{1'b1, 6'd5, 2'd3, 3'b000, 32'd61, 6'd5, 3'b111},
    '{1'b1, 6'd5, 2'd3, 3'b000, 32'd5,  6'd5, 3'b000},
    '{1'b1, 6'd5, 2'd3, 3'b000, 32'd5,  6'd5, 3'b000},
    '{1'b1, 6'd5, 2'd3, 3'b000, 32'd5,  6'd5, 3'b000},
    '{1'b1, 6'd5, 2'd3, 3'b111, 32'd2,  6'd5, 3'b000},
    '{1'b1, 6'd5, 2'd3, 3'b111, 32'd58, 6'd5, 3'b111},
    '{1'b0, 6'd5, 2'd0, 3'b000, 32'd54, 6'd9, 3'b000}
  };

  localparam string TAGS [NVEC] = '{
    "R2 R4", "R4 R5 partial", "R4 single", "R4 valid low", "R5 count zero",
    "R3 up", "R3 top", "R3 down", "R3 down", "R3 down", "R3 bottom",
    "R3 leave bottom", "R3 up again", "R2 other entry"
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] lookupAddr;
  logic        updValid;
  logic [5:0]  updIdx;
  logic [1:0]  updCount;
  logic [2:0]  updTaken;
  logic [5:0]  lookupIdx, treeIdx;
  logic [2:0]  predTaken, treePred;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_branch_predictor #(.IDX_W(6), .ADDR_W(32), .TREE_MODE(1'b0)) uut (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .lookupIdx(lookupIdx),
    .predTaken(predTaken), .updValid(updValid), .updIdx(updIdx),
    .updCount(updCount), .updTaken(updTaken)
  );

  multi_branch_predictor #(.IDX_W(6), .ADDR_W(32), .TREE_MODE(1'b1)) uutTree (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .lookupIdx(treeIdx),
    .predTaken(treePred), .updValid(updValid), .updIdx(updIdx),
    .updCount(updCount), .updTaken(updTaken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [5:0] idx, input logic [1:0] cnt,
                       input logic [2:0] tk, input logic [31:0] addr);
    updValid   = v;
    updIdx     = idx;
    updCount   = cnt;
    updTaken   = tk;
    lookupAddr = addr;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0;
    drive(1'b0, 6'd0, 2'd0, 3'b000, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R6 reset state, R1 index with zero history
    chk("R6 R1 reset idx", 32'(lookupIdx), 32'd0);
    chk("R6 reset pred", 32'(predTaken), 32'd0);
    lookupAddr = 32'd5;
    #1;
    chk("R1 idx addr only", 32'(lookupIdx), 32'd5);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].v, VECS[i].idx, VECS[i].cnt, VECS[i].tk, VECS[i].addr);
      @(negedge clk);
      chk({"R1 ", TAGS[i]}, 32'(lookupIdx), 32'(VECS[i].expIdx));
      chk(TAGS[i], 32'(predTaken), 32'(VECS[i].expPred));
    end
    drive(1'b0, 6'd0, 2'd0, 3'b000, 32'd5);

    // R6 mid-run reset restores counters and history
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R6 midrun idx", 32'(lookupIdx), 32'd5);
    chk("R6 midrun pred", 32'(predTaken), 32'd0);
    lookupAddr = 32'd0;
    #1;
    chk("R6 tree idx", 32'(treeIdx), 32'd0);
    chk("R6 tree pred", 32'(treePred), 32'd0);

    // R7 tree layout: branch 2 -> ctr 2, branch 3 -> ctr 5
    drive(1'b1, 6'd3, 2'd3, 3'b101, 32'd38);
    @(negedge clk);
    chk("R8 tree idx top bit", 32'(treeIdx), 32'd3);
    chk("R7 tree path", 32'(treePred), 32'b101);
    // R8 updIdx top bit ignored (35 hits entry 3)
    drive(1'b1, 6'd35, 2'd3, 3'b111, 32'd12);
    @(negedge clk);
    chk("R8 R7 tree upd alias", 32'(treePred), 32'b101);
    chk("R8 R5 tree hist", 32'(treeIdx), 32'd3);
    drive(1'b1, 6'd3, 2'd3, 3'b111, 32'd28);
    @(negedge clk);
    chk("R7 tree path switch", 32'(treePred), 32'b111);
    chk("R5 tree hist wrap", 32'(treeIdx), 32'd3);
    drive(1'b0, 6'd0, 2'd0, 3'b000, 32'd0);
    @(negedge clk);
    finish();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish();
    end
  end

endmodule